// File: doc/BRIEF.md
# CAN bit timing generator

The block divides the system clock into time quanta and counts quanta through each nominal CAN bit: a one-quantum sync segment, a first phase segment, and a second phase segment. From that count it issues a quantum enable, a strobe at the sample point and a strobe on the last quantum of the bit. It also delivers the received bit, either as one sample taken at the sample point or as the majority of three samples taken around it.

The prescaler, both segment lengths and the sampling mode sit in a timing register. Each length field holds one less than the value in effect. A request/grant handshake guards the register. The controller raises the change request. The block answers with the change-enable status at the next bit boundary, or in the next cycle when the bus is idle. Register writes are taken only while change-enable is high, and the timing counters are held at zero for that whole time. Clearing the request drops change-enable, and timing then restarts from the start of a sync quantum with the new values. While the bus is idle, a falling edge on the receive line restarts the bit at its sync quantum.

Top module: `can_bit_timing`

## Requirements
- R1: `tq_en_o` is high for one cycle in every (`cfg_brp_i` value stored + 1) cycles of `clk_i` while timing runs.
- R2: A bit lasts 1 + (stored first-segment field + 1) + (effective second-segment field + 1) quanta. `bit_end_o` is high together with `tq_en_o` on the last quantum of the bit.
- R3: `sample_o` is high together with `tq_en_o` at the end of quantum number (first-segment field + 1), counting the sync quantum as 0. With fields 10 and 2 this is 12 quanta after the bit starts, in a 15-quantum bit.
- R4: A stored second-segment field of 0 acts as 1, so the second phase segment is at least 2 quanta long.
- R5: With the sampling-mode bit at 0, `rx_bit_o` takes the value of `rx_i` present in the `sample_o` cycle, and shows it from the next cycle.
- R6: With the sampling-mode bit at 1, `rx_bit_o` becomes the majority of `rx_i` taken at the quantum strobes ending quanta F, F+1 and F+2 (F = first-segment field). It changes in the cycle after the third of those strobes.
- R7: `chg_en_o` rises in the cycle after a cycle in which `chg_req_i` is 1 and either `bus_idle_i` or `bit_end_o` is 1. It falls in the cycle after `chg_req_i` is seen at 0.
- R8: A `cfg_we_i` pulse loads the four timing fields only if `chg_en_o` is 1 in that cycle. Otherwise the pulse is ignored.
- R9: While `chg_en_o` is 1, `tq_en_o`, `sample_o` and `bit_end_o` stay 0. In the first cycle with `chg_en_o` back at 0 the prescaler starts from zero, so the first `tq_en_o` comes (prescaler field) cycles later.
- R10: If `bus_idle_i` is 1, `chg_en_o` is 0 and `rx_i` goes from 1 to 0, no strobe is issued in that cycle. Quantum 0 of a new bit starts in the next cycle, with its first `tq_en_o` (prescaler field + 1) cycles after the edge cycle.
- R11: After reset `chg_en_o` is 0 and `rx_bit_o` is 1. All timing fields are 0, which gives a 4-cycle bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chg_req_i | input | 1 | Request to change timing fields |
| bus_idle_i | input | 1 | Bus idle indication from the controller |
| cfg_we_i | input | 1 | Timing register write strobe |
| cfg_brp_i | input | BRP_W | Prescaler field (divide minus one) |
| cfg_tseg1_i | input | T1_W | First phase segment field (quanta minus one) |
| cfg_tseg2_i | input | T2_W | Second phase segment field (quanta minus one) |
| cfg_sam_i | input | 1 | Sampling mode: 0 single, 1 majority of three |
| rx_i | input | 1 | Receive line, synchronous to clk_i |
| chg_en_o | output | 1 | Change-enable status: timing fields writable |
| tq_en_o | output | 1 | Time quantum enable |
| sample_o | output | 1 | Sample point strobe |
| bit_end_o | output | 1 | Last quantum of the bit strobe |
| rx_bit_o | output | 1 | Sampled receive bit |

## Verification
Two functions can land in the same cycle. A hard-sync edge on `rx_i` can arrive in the very cycle in which the prescaler would issue a quantum strobe, and possibly a bit-end strobe. A change request can also meet a bit-end strobe. The bench provokes the first case by driving random receive levels while the bus is flagged idle, which sweeps edges across every prescaler phase, and the second by raising requests while bits are running. A behavioural model predicts every output in every cycle and is compared on every clock: the sync edge must win and suppress the strobe, and the grant must follow the bit end that coincided with the request.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
  typedef enum logic {
    SAMP_ONE   = 1'b0,
    SAMP_THREE = 1'b1
  } samp_mode_e;

  function automatic logic maj3(logic a, logic b, logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/cbt_cfg_lock.sv
module cbt_cfg_lock
  import cbt_pkg::*;
#(
  parameter int unsigned BRP_W   = 6,
  parameter int unsigned T1_W    = 4,
  parameter int unsigned T2_W    = 3,
  parameter logic [BRP_W-1:0] RST_BRP = '0,
  parameter logic [T1_W-1:0]  RST_T1  = '0,
  parameter logic [T2_W-1:0]  RST_T2  = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             chg_req_i,
  input  logic             bus_idle_i,
  input  logic             bit_end_i,
  input  logic             we_i,
  input  logic [BRP_W-1:0] brp_i,
  input  logic [T1_W-1:0]  t1_i,
  input  logic [T2_W-1:0]  t2_i,
  input  logic             sam_i,
  output logic             chg_en_o,
  output logic [BRP_W-1:0] brp_o,
  output logic [T1_W-1:0]  t1_o,
  output logic [T2_W-1:0]  t2_o,
  output samp_mode_e       sam_o
);
  logic cce_q;
  logic grant, release_req;

  assign grant       = chg_req_i && !cce_q && (bus_idle_i || bit_end_i);
  assign release_req = !chg_req_i && cce_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cce_q <= 1'b0;
    end else if (grant) begin
      cce_q <= 1'b1;
    end else if (release_req) begin
      cce_q <= 1'b0;
    end
  end

  // fields load only while the lock is open
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      brp_o <= RST_BRP;
      t1_o  <= RST_T1;
      t2_o  <= RST_T2;
      sam_o <= SAMP_ONE;
    end else if (we_i && cce_q) begin
      brp_o <= brp_i;
      t1_o  <= t1_i;
      t2_o  <= t2_i;
      sam_o <= samp_mode_e'(sam_i);
    end
  end

  assign chg_en_o = cce_q;
endmodule

// File: rtl/cbt_prescaler.sv
module cbt_prescaler #(
  parameter int unsigned BRP_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic             restart_i,
  input  logic [BRP_W-1:0] brp_i,
  output logic             tq_en_o
);
  logic [BRP_W-1:0] cnt_q;
  logic             wrap;

  assign wrap    = (cnt_q == brp_i);
  assign tq_en_o = wrap && !hold_i && !restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (hold_i || restart_i || wrap) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + BRP_W'(1);
    end
  end
endmodule

// File: rtl/cbt_seg_ctr.sv
module cbt_seg_ctr #(
  parameter int unsigned T1_W = 4,
  parameter int unsigned T2_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hold_i,
  input  logic            restart_i,
  input  logic            tq_en_i,
  input  logic [T1_W-1:0] t1_i,
  input  logic [T2_W-1:0] t2_i,
  output logic            tap_pre_o,
  output logic            sample_o,
  output logic            tap_post_o,
  output logic            bit_end_o
);
  localparam int unsigned NBT_MAX = 1 + (2 ** T1_W) + (2 ** T2_W);
  localparam int unsigned QW      = $clog2(NBT_MAX);

  logic [QW-1:0] q_q;
  logic [QW-1:0] t1_len, t2_len;
  logic [QW-1:0] idx_pre, idx_samp, idx_post, idx_last;

  assign t1_len   = QW'(t1_i) + QW'(1);
  // second segment never below 2 quanta
  assign t2_len   = (t2_i == '0) ? QW'(2) : (QW'(t2_i) + QW'(1));
  assign idx_pre  = QW'(t1_i);
  assign idx_samp = t1_len;
  assign idx_post = t1_len + QW'(1);
  assign idx_last = t1_len + t2_len;

  assign tap_pre_o  = tq_en_i && (q_q == idx_pre);
  assign sample_o   = tq_en_i && (q_q == idx_samp);
  assign tap_post_o = tq_en_i && (q_q == idx_post);
  assign bit_end_o  = tq_en_i && (q_q == idx_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= '0;
    end else if (hold_i || restart_i || bit_end_o) begin
      q_q <= '0;
    end else if (tq_en_i) begin
      q_q <= q_q + QW'(1);
    end
  end
endmodule

// File: rtl/cbt_sampler.sv
module cbt_sampler
  import cbt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_i,
  input  logic       bus_idle_i,
  input  logic       hold_i,
  input  samp_mode_e mode_i,
  input  logic       tap_pre_i,
  input  logic       tap_mid_i,
  input  logic       tap_post_i,
  output logic       hsync_o,
  output logic       rx_bit_o
);
  logic rx_q;
  logic s_pre_q, s_mid_q;
  logic bit_q;

  assign hsync_o = rx_q && !rx_i && bus_idle_i && !hold_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q <= 1'b1;
    end else begin
      rx_q <= rx_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_pre_q <= 1'b1;
      s_mid_q <= 1'b1;
    end else begin
      if (tap_pre_i) s_pre_q <= rx_i;
      if (tap_mid_i) s_mid_q <= rx_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= 1'b1;
    end else if (mode_i == SAMP_ONE) begin
      if (tap_mid_i) bit_q <= rx_i;
    end else begin
      if (tap_post_i) bit_q <= maj3(s_pre_q, s_mid_q, rx_i);
    end
  end

  assign rx_bit_o = bit_q;
endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing
  import cbt_pkg::*;
#(
  parameter int unsigned BRP_W = 6,
  parameter int unsigned T1_W  = 4,
  parameter int unsigned T2_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             chg_req_i,
  input  logic             bus_idle_i,
  input  logic             cfg_we_i,
  input  logic [BRP_W-1:0] cfg_brp_i,
  input  logic [T1_W-1:0]  cfg_tseg1_i,
  input  logic [T2_W-1:0]  cfg_tseg2_i,
  input  logic             cfg_sam_i,
  input  logic             rx_i,
  output logic             chg_en_o,
  output logic             tq_en_o,
  output logic             sample_o,
  output logic             bit_end_o,
  output logic             rx_bit_o
);
  logic [BRP_W-1:0] brp_q;
  logic [T1_W-1:0]  t1_q;
  logic [T2_W-1:0]  t2_q;
  samp_mode_e       sam_q;
  logic             cce, hsync, tq_en;
  logic             tap_pre, tap_mid, tap_post, bit_end;

  cbt_cfg_lock #(
    .BRP_W(BRP_W), .T1_W(T1_W), .T2_W(T2_W)
  ) u_lock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .chg_req_i (chg_req_i),
    .bus_idle_i(bus_idle_i),
    .bit_end_i (bit_end),
    .we_i      (cfg_we_i),
    .brp_i     (cfg_brp_i),
    .t1_i      (cfg_tseg1_i),
    .t2_i      (cfg_tseg2_i),
    .sam_i     (cfg_sam_i),
    .chg_en_o  (cce),
    .brp_o     (brp_q),
    .t1_o      (t1_q),
    .t2_o      (t2_q),
    .sam_o     (sam_q)
  );

  cbt_prescaler #(.BRP_W(BRP_W)) u_presc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hold_i   (cce),
    .restart_i(hsync),
    .brp_i    (brp_q),
    .tq_en_o  (tq_en)
  );

  cbt_seg_ctr #(.T1_W(T1_W), .T2_W(T2_W)) u_seg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hold_i    (cce),
    .restart_i (hsync),
    .tq_en_i   (tq_en),
    .t1_i      (t1_q),
    .t2_i      (t2_q),
    .tap_pre_o (tap_pre),
    .sample_o  (tap_mid),
    .tap_post_o(tap_post),
    .bit_end_o (bit_end)
  );

  cbt_sampler u_samp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rx_i      (rx_i),
    .bus_idle_i(bus_idle_i),
    .hold_i    (cce),
    .mode_i    (sam_q),
    .tap_pre_i (tap_pre),
    .tap_mid_i (tap_mid),
    .tap_post_i(tap_post),
    .hsync_o   (hsync),
    .rx_bit_o  (rx_bit_o)
  );

  assign chg_en_o  = cce;
  assign tq_en_o   = tq_en;
  assign sample_o  = tap_mid;
  assign bit_end_o = bit_end;
endmodule

// File: rtl/cbt_checker.sv
module cbt_checker #(
  parameter int unsigned BRP_W = 6,
  parameter int unsigned T1_W  = 4,
  parameter int unsigned T2_W  = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             chg_req_i,
  input logic             bus_idle_i,
  input logic             rx_i,
  input logic             chg_en_o,
  input logic             tq_en_o,
  input logic             sample_o,
  input logic             bit_end_o,
  input logic [BRP_W-1:0] brp_q,
  input logic [T1_W-1:0]  t1_q,
  input logic [T2_W-1:0]  t2_q,
  input logic             sam_q
);
  p_tq_gap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tq_en_o && brp_q != '0) |=> !tq_en_o);

  p_end_on_tq_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_end_o |-> tq_en_o);

  p_sample_on_tq_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> tq_en_o);

  p_phase2_nonzero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sample_o && bit_end_o));

  p_cce_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(chg_en_o) |-> ($past(chg_req_i) && ($past(bus_idle_i) || $past(bit_end_o))));

  p_cce_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(chg_en_o) |-> !$past(chg_req_i));

  p_cfg_locked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chg_en_o |=> ($stable(brp_q) && $stable(t1_q) && $stable(t2_q) && $stable(sam_q)));

  p_quiet_in_cfg_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_en_o |-> (!tq_en_o && !sample_o && !bit_end_o));

  p_hsync_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_idle_i && !chg_en_o && $past(rx_i) && !rx_i) |-> !tq_en_o);
endmodule

bind can_bit_timing cbt_checker #(.BRP_W(BRP_W), .T1_W(T1_W), .T2_W(T2_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .chg_req_i (chg_req_i),
  .bus_idle_i(bus_idle_i),
  .rx_i      (rx_i),
  .chg_en_o  (chg_en_o),
  .tq_en_o   (tq_en_o),
  .sample_o  (sample_o),
  .bit_end_o (bit_end_o),
  .brp_q     (brp_q),
  .t1_q      (t1_q),
  .t2_q      (t2_q),
  .sam_q     (sam_q)
);

// File: tb/can_bit_timing_tb_top.sv
`timescale 1ns/1ps
module can_bit_timing_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       chg_req_i = 1'b0;
  logic       bus_idle_i = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [5:0] cfg_brp_i = '0;
  logic [3:0] cfg_tseg1_i = '0;
  logic [2:0] cfg_tseg2_i = '0;
  logic       cfg_sam_i = 1'b0;
  logic       rx_i = 1'b1;
  logic       chg_en_o, tq_en_o, sample_o, bit_end_o, rx_bit_o;

  int n_cmp = 0, n_bad = 0;
  bit cmp_en = 0, rx_rand = 0, done = 0;
  logic rx_fix = 1'b1;

  can_bit_timing dut_i (.*);

  always #4 clk_i = ~clk_i;

  // rx driver, single source
  always @(posedge clk_i) begin
    #2;
    rx_i = rx_rand ? 1'($urandom_range(0, 1)) : rx_fix;
  end

  // behavioural reference
  int m_pc, m_q, m_cce, m_brp, m_t1, m_t2, m_sam, m_rxp, m_s0, m_s1, m_bit;
  int o_tq, o_smp, o_end, o_pre, o_post, o_hs;

  task automatic m_outs();
    int nbt, t2e;
    t2e   = (m_t2 == 0) ? 1 : m_t2;
    nbt   = 1 + (m_t1 + 1) + (t2e + 1);
    o_hs  = (m_rxp == 1 && rx_i == 1'b0 && bus_idle_i && m_cce == 0) ? 1 : 0;
    o_tq  = (m_cce == 0 && o_hs == 0 && m_pc == m_brp) ? 1 : 0;
    o_pre = (o_tq == 1 && m_q == m_t1) ? 1 : 0;
    o_smp = (o_tq == 1 && m_q == m_t1 + 1) ? 1 : 0;
    o_post= (o_tq == 1 && m_q == m_t1 + 2) ? 1 : 0;
    o_end = (o_tq == 1 && m_q == nbt - 1) ? 1 : 0;
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pc = 0; m_q = 0; m_cce = 0; m_brp = 0; m_t1 = 0; m_t2 = 0; m_sam = 0;
      m_rxp = 1; m_s0 = 1; m_s1 = 1; m_bit = 1;
    end else begin
      int old_cce, r;
      m_outs();
      old_cce = m_cce;
      r = int'(rx_i);
      if (m_cce == 0 && chg_req_i && (bus_idle_i || o_end == 1)) m_cce = 1;
      else if (m_cce == 1 && !chg_req_i) m_cce = 0;
      if (old_cce == 1 && cfg_we_i) begin
        m_brp = int'(cfg_brp_i); m_t1 = int'(cfg_tseg1_i);
        m_t2 = int'(cfg_tseg2_i); m_sam = int'(cfg_sam_i);
      end
      if (m_sam == 0) begin
        if (o_smp == 1) m_bit = r;
      end else if (o_post == 1) m_bit = (m_s0 + m_s1 + r >= 2) ? 1 : 0;
      if (o_pre == 1) m_s0 = r;
      if (o_smp == 1) m_s1 = r;
      if (old_cce == 1 || o_hs == 1) begin m_pc = 0; m_q = 0; end
      else begin
        m_pc = (m_pc == m_brp) ? 0 : m_pc + 1;
        if (o_end == 1) m_q = 0; else if (o_tq == 1) m_q = m_q + 1;
      end
      m_rxp = r;
    end
  end

  task automatic check(int act, int exp, string req);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (cmp_en && rst_ni) begin
      m_outs();
      check(int'(tq_en_o),   o_tq,  "R1 tq_en");
      check(int'(bit_end_o), o_end, "R2 bit_end");
      check(int'(sample_o),  o_smp, "R3 sample");
      check(int'(chg_en_o),  m_cce, "R7 chg_en");
      check(int'(rx_bit_o),  m_bit, (m_sam == 1) ? "R6 rx_bit" : "R5 rx_bit");
    end
  end

  task automatic step();
    @(posedge clk_i); #2;
  endtask

  task automatic wait_end();
    do @(negedge clk_i); while (!bit_end_o);
  endtask

  task automatic period(int exp, string req);
    int n = 0;
    wait_end();
    do begin @(negedge clk_i); n++; end while (!bit_end_o);
    check(n, exp, req);
  endtask

  task automatic smp_offset(int exp, string req);
    int n = 0;
    wait_end();
    do begin @(negedge clk_i); n++; end while (!sample_o);
    check(n, exp, req);
  endtask

  task automatic cfg_write(int brp, int t1, int t2, int sam);
    int n = 0;
    step(); chg_req_i = 1'b1;
    do @(negedge clk_i); while (!chg_en_o);
    check(int'(tq_en_o), 0, "R9 quiet");
    step(); cfg_we_i = 1'b1;
    cfg_brp_i = 6'(brp); cfg_tseg1_i = 4'(t1); cfg_tseg2_i = 3'(t2); cfg_sam_i = 1'(sam);
    step(); cfg_we_i = 1'b0; chg_req_i = 1'b0;
    do @(negedge clk_i); while (chg_en_o);
    while (!tq_en_o) begin @(negedge clk_i); n++; end
    check(n, brp, "R9 restart");
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1; cmp_en = 1;
    @(negedge clk_i);
    check(int'(chg_en_o), 0, "R11 chg_en");
    check(int'(rx_bit_o), 1, "R11 rx_bit");
    period(4, "R11 default bit");

    // write while locked: ignored
    step(); cfg_we_i = 1'b1; cfg_brp_i = 6'd5; cfg_tseg1_i = 4'd7;
    step(); cfg_we_i = 1'b0;
    period(4, "R8 locked write");

    cfg_write(1, 10, 2, 0);
    rx_rand = 1;
    period(30, "R2 bit length");
    smp_offset(24, "R3 sample point");
    repeat (300) step();

    rx_rand = 0; rx_fix = 1'b0;
    wait_end(); wait_end();
    check(int'(rx_bit_o), 0, "R5 single low");
    rx_fix = 1'b1;
    wait_end(); wait_end();
    check(int'(rx_bit_o), 1, "R5 single high");

    cfg_write(2, 3, 0, 1);
    period(21, "R4 min phase2");
    smp_offset(15, "R4 sample point");
    rx_fix = 1'b0;
    wait_end(); wait_end();
    check(int'(rx_bit_o), 0, "R6 triple low");
    rx_fix = 1'b1;
    wait_end(); wait_end();
    check(int'(rx_bit_o), 1, "R6 triple high");
    rx_rand = 1;
    repeat (400) step();

    // hard sync on idle bus
    rx_rand = 0; rx_fix = 1'b1;
    step(); bus_idle_i = 1'b1;
    repeat (5) step();
    rx_fix = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    check(int'(tq_en_o), 0, "R10 edge cycle");
    begin
      int n = 0;
      do begin @(negedge clk_i); n++; end while (!tq_en_o);
      check(n, 3, "R10 restart");
    end
    rx_rand = 1;
    repeat (500) step();

    // idle grant is immediate
    step(); chg_req_i = 1'b1;
    @(negedge clk_i); check(int'(chg_en_o), 0, "R7 idle before");
    @(negedge clk_i); check(int'(chg_en_o), 1, "R7 idle grant");
    step(); chg_req_i = 1'b0;
    @(negedge clk_i); @(negedge clk_i);
    check(int'(chg_en_o), 0, "R7 release");
    step(); bus_idle_i = 1'b0;
    cfg_write(0, 0, 0, 0);
    repeat (200) step();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule